// File: doc/BRIEF.md
# DSI Video Packet Decoder

This block sits behind the lane-merge stage of a serial display receiver. It consumes the merged byte stream of a link running in video mode, one byte per enabled cycle, and rebuilds a discrete raster from it. It parses each packet header and checks the header ECC. Sync-start short packets become single-cycle HSYNC and VSYNC pulses. Pixel payloads in 24-bit packed or 18-bit loosely packed form are turned into a 24-bit pixel bus with a data-enable strobe.

Any other traffic is consumed without touching the raster: other data types and packets on other virtual channels. The block verifies the payload CRC of every long packet. Two sticky flags record header and payload errors until reset. A start-of-transmission marker lets the upstream stage resynchronise the parser at any byte.

Top module: `dsi_video_decoder`

## Requirements
- R1: While and after reset, before any input, hsync, vsync, de, pixel, err_ecc and err_crc are all 0.
- R2: A header is four bytes. Byte 0 holds the virtual channel in bits 7:6 and the data type in bits 5:0. Bytes 1 and 2 are the word count, low byte first. Byte 3 is {2'b00,p5..p0}, where p_k is the XOR of the 24 header bits (bit 0 = byte 0 bit 0, bit 23 = byte 2 bit 7) under mask M_k: M0=0xF12CB7, M1=0xF2555B, M2=0x749A6D, M3=0xB8E38E, M4=0xDF03F0, M5=0xEFFC00. A data type whose low nibble is 0x9 or above is a long packet, followed by word-count payload bytes and two CRC bytes. Any other data type is a short packet.
- R3: A header whose byte 3 differs from the computed ECC sets err_ecc, which stays 1 until reset. That packet and every byte after it are ignored until the next in_sot.
- R4: A short packet on channel 0 with type 0x21 gives hsync=1, and type 0x01 gives vsync=1. The pulse lasts exactly the cycle after the clock edge that takes the ECC byte. Types 0x31, 0x11 and other short types give no output.
- R5: In a type 0x3E long packet on channel 0, each group of three payload bytes (first, second, third) yields pixel={first,second,third} with de=1. This appears in the single cycle after the edge that takes the third byte.
- R6: For type 0x2E, each of the three bytes is widened to {b[7:2],b[7:6]} before being placed as in R5.
- R7: Payload bytes left over after the last complete group of three produce no pixel.
- R8: Long packets of any other data type are consumed in full, payload and CRC included, with no output. The packet after them decodes normally.
- R9: Packets on virtual channels other than 0 produce no hsync, vsync or de.
- R10: The CRC is CRC-16 with polynomial x^16+x^12+x^5+1. It is processed least significant bit first (reflected constant 0x8408), seeded with 0xFFFF, with no final inversion, and sent low byte first. A mismatch sets err_crc, which stays 1 until reset. Pixels of that packet are still output, and following packets decode normally.
- R11: A byte accepted with in_sot=1 is always taken as header byte 0. Any packet in progress is abandoned, including a partly gathered pixel.
- R12: Cycles with in_valid=0 change nothing, so idle gaps between bytes do not alter the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_byte carries a link byte this cycle |
| in_sot | input | 1 | This byte is the first of a transmission |
| in_byte | input | 8 | Merged link byte |
| hsync | output | 1 | Line-start pulse |
| vsync | output | 1 | Frame-start pulse |
| de | output | 1 | Pixel strobe |
| pixel | output | 24 | Pixel {first, second, third component} |
| err_ecc | output | 1 | Sticky header ECC error |
| err_crc | output | 1 | Sticky payload CRC error |

## Verification
Recovery from damaged traffic is the hardest behaviour to reach from the ports, because the parser must lose and regain packet framing. The bench corrupts one ECC bit in a long-packet header. It then feeds a byte sequence that would decode as a valid line-start packet if the parser had not dropped into its skip state. After that, a start-of-transmission marker must restore decoding. A second case cuts a pixel packet off mid-payload with a new start-of-transmission marker, so that both the stale word count and the half-gathered pixel are seen to be discarded.

// File: rtl/dsi_pkg.sv
package dsi_pkg;

   typedef enum logic [1:0] {ST_HDR, ST_PAY, ST_CRC, ST_SKIP} dec_state_t;

   localparam logic [5:0] DT_VSYNC_START = 6'h01;
   localparam logic [5:0] DT_VSYNC_END   = 6'h11;
   localparam logic [5:0] DT_HSYNC_START = 6'h21;
   localparam logic [5:0] DT_HSYNC_END   = 6'h31;
   localparam logic [5:0] DT_PIX24       = 6'h3E;
   localparam logic [5:0] DT_PIX18_LOOSE = 6'h2E;

   // long packets: low nibble of the data type from 0x9 upward
   function automatic logic is_long_dt(input logic [3:0] lo);
      return lo >= 4'h9;
   endfunction

   // parity masks of the header ECC, bit 0 = first header byte bit 0
   function automatic logic [23:0] ecc_mask(input int k);
      case (k)
         0:       return 24'hF12CB7;
         1:       return 24'hF2555B;
         2:       return 24'h749A6D;
         3:       return 24'hB8E38E;
         4:       return 24'hDF03F0;
         default: return 24'hEFFC00;
      endcase
   endfunction

endpackage

// File: rtl/dsi_hdr_ecc.sv
module dsi_hdr_ecc #(
   parameter int HDR_BITS = 24,
   parameter int ECC_BITS = 6,
   parameter int OUT_W    = 8
) (
   input  logic [HDR_BITS-1:0] hdr,
   output logic [OUT_W-1:0]    ecc
);
   localparam int PAD_W = OUT_W - ECC_BITS;

   logic [ECC_BITS-1:0] par;

   generate
      if (HDR_BITS != 24) begin : g_bad_hdr
         $error("dsi_hdr_ecc: header must be 24 bits");
      end
      if (ECC_BITS > 6 || PAD_W < 1) begin : g_bad_ecc
         $error("dsi_hdr_ecc: ECC width out of range");
      end
      for (genvar k = 0; k < ECC_BITS; k++) begin : g_par
         assign par[k] = ^(hdr & dsi_pkg::ecc_mask(k));
      end
   endgenerate

   assign ecc = {{PAD_W{1'b0}}, par};

endmodule

// File: rtl/dsi_crc16.sv
module dsi_crc16 #(
   parameter int          CRC_W  = 16,
   parameter int          DATA_W = 8,
   parameter logic [15:0] POLY_R = 16'h8408,
   parameter logic [15:0] SEED   = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [DATA_W-1:0] din,
   output logic [CRC_W-1:0]  crc
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_next;

   generate
      if (CRC_W != 16 || DATA_W > CRC_W) begin : g_bad
         $error("dsi_crc16: unsupported widths");
      end
   endgenerate

   always_comb begin
      crc_next = crc_q ^ {{(CRC_W-DATA_W){1'b0}}, din};
      for (int i = 0; i < DATA_W; i++) begin
         if (crc_next[0]) crc_next = (crc_next >> 1) ^ POLY_R;
         else             crc_next = crc_next >> 1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   crc_q <= SEED;
      else if (clr) crc_q <= SEED;
      else if (en)  crc_q <= crc_next;
   end

   assign crc = crc_q;

   // R10: the running CRC only moves on payload bytes or a restart
   assert_crc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(crc_q));

endmodule

// File: rtl/dsi_pixel_unpack.sv
module dsi_pixel_unpack #(
   parameter int COMP_W   = 8,
   parameter int N_COMP   = 3,
   parameter int NARROW_W = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     restart,
   input  logic                     byte_en,
   input  logic [COMP_W-1:0]        byte_in,
   input  logic                     fmt_loose,
   output logic                     pix_valid,
   output logic [COMP_W*N_COMP-1:0] pix_data
);
   localparam int PIX_W = COMP_W * N_COMP;
   localparam int CNT_W = $clog2(N_COMP);
   localparam int REP_W = COMP_W - NARROW_W;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(N_COMP - 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [COMP_W-1:0] held_q [N_COMP-1];
   logic [COMP_W-1:0] raw    [N_COMP];
   logic [COMP_W-1:0] wide   [N_COMP];
   logic [PIX_W-1:0]  pix_next;
   logic              valid_q;
   logic [PIX_W-1:0]  data_q;

   generate
      if (N_COMP < 2 || NARROW_W >= COMP_W || REP_W > NARROW_W) begin : g_bad
         $error("dsi_pixel_unpack: unsupported component layout");
      end
      for (genvar k = 0; k < N_COMP - 1; k++) begin : g_held
         assign raw[k] = held_q[k];
      end
      assign raw[N_COMP-1] = byte_in;
      for (genvar k = 0; k < N_COMP; k++) begin : g_wide
         assign wide[k] = fmt_loose
            ? {raw[k][COMP_W-1 -: NARROW_W], raw[k][COMP_W-1 -: REP_W]}
            : raw[k];
         assign pix_next[(N_COMP-1-k)*COMP_W +: COMP_W] = wide[k];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         valid_q <= 1'b0;
         data_q  <= '0;
         for (int i = 0; i < N_COMP - 1; i++) held_q[i] <= '0;
      end else begin
         valid_q <= 1'b0;
         if (restart) begin
            cnt_q <= '0;
         end else if (byte_en) begin
            if (cnt_q == LAST) begin
               cnt_q   <= '0;
               valid_q <= 1'b1;
               data_q  <= pix_next;
            end else begin
               held_q[cnt_q] <= byte_in;
               cnt_q         <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign pix_valid = valid_q;
   assign pix_data  = data_q;

   // R5: a pixel needs several bytes, so strobes never come back to back
   assert_pix_spaced_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);

endmodule

// File: rtl/dsi_video_decoder.sv
module dsi_video_decoder #(
   parameter int          VC_W      = 2,
   parameter int          DT_W      = 6,
   parameter int          WC_W      = 16,
   parameter int          COMP_W    = 8,
   parameter int          N_COMP    = 3,
   parameter int          NARROW_W  = 6,
   parameter logic [1:0]  VC_ACCEPT = 2'd0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic        in_sot,
   input  logic [7:0]  in_byte,
   output logic        hsync,
   output logic        vsync,
   output logic        de,
   output logic [23:0] pixel,
   output logic        err_ecc,
   output logic        err_crc
);
   import dsi_pkg::*;

   localparam int BYTE_W = VC_W + DT_W;
   localparam int PIX_W  = COMP_W * N_COMP;

   generate
      if (BYTE_W != 8 || WC_W != 16 || PIX_W != 24) begin : g_bad
         $error("dsi_video_decoder: field widths do not fit the byte stream");
      end
   endgenerate

   dec_state_t       st_q;
   logic [1:0]       hidx_q;
   logic [7:0]       hb0_q, hb1_q, hb2_q;
   logic [WC_W-1:0]  wcnt_q;
   logic [7:0]       crc_lo_q;
   logic             cidx_q;
   logic             vid_q, loose_q;
   logic             hs_q, vs_q;
   logic             eccerr_q, crcerr_q;

   logic [VC_W-1:0]  hdr_vc;
   logic [DT_W-1:0]  hdr_dt;
   logic [WC_W-1:0]  hdr_wc;
   logic [7:0]       ecc_calc;
   logic [15:0]      crc_val;
   logic             take_hdr, hdr_done, ecc_ok, hdr_long;
   logic [1:0]       hdr_pos;
   logic             pay_byte, crc_byte, pkt_start, crc_bad;
   logic             on_chan, is_pix24, is_pix18;

   assign hdr_vc   = hb0_q[7:6];
   assign hdr_dt   = hb0_q[5:0];
   assign hdr_wc   = {hb2_q, hb1_q};

   assign take_hdr = in_valid && (in_sot || st_q == ST_HDR);
   assign hdr_pos  = in_sot ? 2'd0 : hidx_q;
   assign hdr_done = take_hdr && hdr_pos == 2'd3;
   assign ecc_ok   = ecc_calc == in_byte;
   assign hdr_long = is_long_dt(hdr_dt[3:0]);
   assign on_chan  = hdr_vc == VC_ACCEPT;
   assign is_pix24 = hdr_dt == DT_PIX24;
   assign is_pix18 = hdr_dt == DT_PIX18_LOOSE;

   assign pay_byte  = in_valid && !in_sot && st_q == ST_PAY;
   assign crc_byte  = in_valid && !in_sot && st_q == ST_CRC;
   assign pkt_start = hdr_done && ecc_ok && hdr_long;
   assign crc_bad   = {in_byte, crc_lo_q} != crc_val;

   dsi_hdr_ecc #(.HDR_BITS(24), .ECC_BITS(6), .OUT_W(8)) u_ecc (
      .hdr ({hb2_q, hb1_q, hb0_q}),
      .ecc (ecc_calc)
   );

   dsi_crc16 #(.CRC_W(16), .DATA_W(8)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pkt_start),
      .en    (pay_byte),
      .din   (in_byte),
      .crc   (crc_val)
   );

   dsi_pixel_unpack #(.COMP_W(COMP_W), .N_COMP(N_COMP), .NARROW_W(NARROW_W)) u_unpack (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (pkt_start || (in_valid && in_sot)),
      .byte_en   (pay_byte && vid_q),
      .byte_in   (in_byte),
      .fmt_loose (loose_q),
      .pix_valid (de),
      .pix_data  (pixel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_HDR;
         hidx_q   <= 2'd0;
         hb0_q    <= '0;
         hb1_q    <= '0;
         hb2_q    <= '0;
         wcnt_q   <= '0;
         crc_lo_q <= '0;
         cidx_q   <= 1'b0;
         vid_q    <= 1'b0;
         loose_q  <= 1'b0;
         hs_q     <= 1'b0;
         vs_q     <= 1'b0;
         eccerr_q <= 1'b0;
         crcerr_q <= 1'b0;
      end else begin
         hs_q <= 1'b0;
         vs_q <= 1'b0;
         if (take_hdr) begin
            case (hdr_pos)
               2'd0: begin
                  hb0_q  <= in_byte;
                  hidx_q <= 2'd1;
                  st_q   <= ST_HDR;
               end
               2'd1: begin
                  hb1_q  <= in_byte;
                  hidx_q <= 2'd2;
               end
               2'd2: begin
                  hb2_q  <= in_byte;
                  hidx_q <= 2'd3;
               end
               default: begin
                  hidx_q <= 2'd0;
                  if (!ecc_ok) begin
                     eccerr_q <= 1'b1;
                     st_q     <= ST_SKIP;
                  end else if (hdr_long) begin
                     wcnt_q  <= hdr_wc;
                     vid_q   <= on_chan && (is_pix24 || is_pix18);
                     loose_q <= is_pix18;
                     cidx_q  <= 1'b0;
                     st_q    <= (hdr_wc == '0) ? ST_CRC : ST_PAY;
                  end else if (on_chan) begin
                     hs_q <= hdr_dt == DT_HSYNC_START;
                     vs_q <= hdr_dt == DT_VSYNC_START;
                  end
               end
            endcase
         end else if (pay_byte) begin
            wcnt_q <= wcnt_q - 1'b1;
            if (wcnt_q == WC_W'(1)) begin
               st_q   <= ST_CRC;
               cidx_q <= 1'b0;
            end
         end else if (crc_byte) begin
            if (!cidx_q) begin
               crc_lo_q <= in_byte;
               cidx_q   <= 1'b1;
            end else begin
               cidx_q <= 1'b0;
               st_q   <= ST_HDR;
               if (crc_bad) crcerr_q <= 1'b1;
            end
         end
      end
   end

   assign hsync   = hs_q;
   assign vsync   = vs_q;
   assign err_ecc = eccerr_q;
   assign err_crc = crcerr_q;

   // R4: sync outputs are single-cycle pulses
   assert_hs_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hsync |=> !hsync);
   assert_vs_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |=> !vsync);
   // R5: a pixel strobe is never coincident with a sync pulse and follows a payload byte
   assert_sync_vs_pixel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !((hsync || vsync) && de));
   assert_de_from_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> $past(st_q) == ST_PAY);
   // R3: sticky header error, and silence while skipping
   assert_ecc_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      err_ecc |=> err_ecc);
   assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SKIP && !(in_valid && in_sot)) |=> (!hsync && !vsync && !de));
   // R10: sticky payload error
   assert_crc_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_crc |=> err_crc);

endmodule

// File: tb/dsi_video_decoder_bench.sv
`timescale 1ns/1ps
module dsi_video_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sot = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        hsync, vsync, de, err_ecc, err_crc;
   logic [23:0] pixel;

   always #2.5 clk = ~clk;

   dsi_video_decoder u_dsi_video_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sot(in_sot),
      .in_byte(in_byte), .hsync(hsync), .vsync(vsync), .de(de),
      .pixel(pixel), .err_ecc(err_ecc), .err_crc(err_crc)
   );

   typedef struct packed {
      logic [1:0]  kind;   // 1 hsync, 2 vsync, 3 pixel
      logic [3:0]  req;
      logic [23:0] px;
   } ev_t;

   ev_t        expq[$];
   logic [7:0] pay[$];
   int         n_vec = 0;
   int         n_bad = 0;
   int         gap = 0;
   bit         done = 1'b0;

   function automatic logic [7:0] ecc_of(input logic [23:0] d);
      logic [23:0] m [6];
      logic [7:0]  e;
      m[0] = 24'hF12CB7; m[1] = 24'hF2555B; m[2] = 24'h749A6D;
      m[3] = 24'hB8E38E; m[4] = 24'hDF03F0; m[5] = 24'hEFFC00;
      e = 8'h00;
      for (int k = 0; k < 6; k++) e[k] = ^(d & m[k]);
      return e;
   endfunction

   function automatic logic [15:0] crc_of();
      logic [15:0] c;
      c = 16'hFFFF;
      foreach (pay[i]) begin
         c = c ^ {8'h00, pay[i]};
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
      end
      return c;
   endfunction

   function automatic logic [7:0] widen(input logic [7:0] b, input bit loose);
      return loose ? {b[7:2], b[7:6]} : b;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b, input logic s);
      in_valid = 1'b1;
      in_byte  = b;
      in_sot   = s;
      @(negedge clk);
      in_valid = 1'b0;
      in_sot   = 1'b0;
      in_byte  = 8'hA5;
      repeat (gap) @(negedge clk);
   endtask

   task automatic send_hdr(input logic [1:0] vc, input logic [5:0] dt,
                           input logic [15:0] wc, input logic s, input bit bad_ecc);
      logic [7:0] b0;
      logic [7:0] e;
      b0 = {vc, dt};
      e  = ecc_of({wc[15:8], wc[7:0], b0}) ^ (bad_ecc ? 8'h04 : 8'h00);
      put(b0, s);
      put(wc[7:0], 1'b0);
      put(wc[15:8], 1'b0);
      put(e, 1'b0);
   endtask

   task automatic send_short(input logic [1:0] vc, input logic [5:0] dt,
                             input logic s, input logic [3:0] req);
      if (vc == 2'd0 && dt == 6'h21) expq.push_back('{kind: 2'd1, req: req, px: 24'h0});
      if (vc == 2'd0 && dt == 6'h01) expq.push_back('{kind: 2'd2, req: req, px: 24'h0});
      send_hdr(vc, dt, 16'h0000, s, 1'b0);
   endtask

   task automatic send_long(input logic [1:0] vc, input logic [5:0] dt, input logic s,
                            input bit bad_crc, input logic [3:0] req);
      logic [15:0] c;
      bit          loose;
      int          n;
      n     = pay.size();
      loose = (dt == 6'h2E);
      if (vc == 2'd0 && (dt == 6'h3E || dt == 6'h2E)) begin
         for (int i = 0; i + 2 < n; i += 3)
            expq.push_back('{kind: 2'd3, req: req,
               px: {widen(pay[i], loose), widen(pay[i+1], loose), widen(pay[i+2], loose)}});
      end
      c = crc_of() ^ (bad_crc ? 16'h0001 : 16'h0000);
      send_hdr(vc, dt, 16'(n), s, 1'b0);
      foreach (pay[i]) put(pay[i], 1'b0);
      put(c[7:0], 1'b0);
      put(c[15:8], 1'b0);
   endtask

   // scoreboard monitor, sampling away from the active edge
   always @(negedge clk) begin
      if (rst_n && (hsync || vsync || de)) begin
         ev_t         e;
         logic [1:0]  k;
         k = de ? 2'd3 : (hsync ? 2'd1 : 2'd2);
         n_vec++;
         if (expq.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected output event: actual kind %0d pixel %h expected none", k, pixel);
         end else begin
            e = expq.pop_front();
            if (k !== e.kind || (k == 2'd3 && pixel !== e.px)) begin
               n_bad++;
               $display("FAIL R%0d: actual kind %0d pixel %h expected kind %0d pixel %h",
                        e.req, k, pixel, e.kind, e.px);
            end
         end
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_vec++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      check("R1 hsync", {31'b0, hsync}, 0);
      check("R1 vsync", {31'b0, vsync}, 0);
      check("R1 de", {31'b0, de}, 0);
      check("R1 pixel", {8'b0, pixel}, 0);
      check("R1 err_ecc", {31'b0, err_ecc}, 0);
      check("R1 err_crc", {31'b0, err_crc}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 / R2: sync short packets, end types silent
      send_short(2'd0, 6'h01, 1'b1, 4'd4);
      send_short(2'd0, 6'h21, 1'b0, 4'd4);
      send_short(2'd0, 6'h31, 1'b0, 4'd4);
      send_short(2'd0, 6'h11, 1'b0, 4'd4);

      // R5: packed 24-bit line of four pixels
      pay = '{8'h12, 8'h34, 8'h56, 8'hFF, 8'h00, 8'h80,
              8'h01, 8'h02, 8'h03, 8'hA5, 8'h5A, 8'hC3};
      send_long(2'd0, 6'h3E, 1'b0, 1'b0, 4'd5);

      // R6 and R12: loosely packed 18-bit with idle gaps between bytes
      gap = 2;
      pay = '{8'hFC, 8'h40, 8'h80, 8'hC3, 8'h7F, 8'h01, 8'h00, 8'hBE, 8'h55};
      send_long(2'd0, 6'h2E, 1'b0, 1'b0, 4'd6);
      gap = 0;

      // R7: trailing partial group
      pay = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
      send_long(2'd0, 6'h3E, 1'b0, 1'b0, 4'd7);

      // R8: non-video long packet whose payload looks like a sync header
      pay = '{8'h21, 8'h00, 8'h00, ecc_of(24'h000021), 8'h01, 8'h00};
      send_long(2'd0, 6'h29, 1'b0, 1'b0, 4'd8);
      send_short(2'd0, 6'h05, 1'b0, 4'd8);
      send_short(2'd0, 6'h21, 1'b0, 4'd8);

      // R9: other virtual channel
      send_short(2'd1, 6'h21, 1'b0, 4'd9);
      pay = '{8'h9A, 8'hBC, 8'hDE};
      send_long(2'd2, 6'h3E, 1'b0, 1'b0, 4'd9);
      send_short(2'd0, 6'h21, 1'b0, 4'd9);
      repeat (3) @(negedge clk);
      check("R10 err_crc clean", {31'b0, err_crc}, 0);
      check("R3 err_ecc clean", {31'b0, err_ecc}, 0);

      // R10: bad CRC keeps pixels, sets flag, later packets decode
      pay = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h00, 8'h42};
      send_long(2'd0, 6'h3E, 1'b0, 1'b1, 4'd10);
      repeat (2) @(negedge clk);
      check("R10 err_crc set", {31'b0, err_crc}, 1);
      check("R10 err_ecc unaffected", {31'b0, err_ecc}, 0);
      send_short(2'd0, 6'h21, 1'b0, 4'd10);

      // R3: bad header ECC; following valid-looking bytes ignored
      send_hdr(2'd0, 6'h3E, 16'd3, 1'b0, 1'b1);
      put(8'h21, 1'b0); put(8'h00, 1'b0); put(8'h00, 1'b0); put(ecc_of(24'h000021), 1'b0);
      put(8'h01, 1'b0); put(8'h00, 1'b0); put(8'h00, 1'b0); put(ecc_of(24'h000001), 1'b0);
      repeat (2) @(negedge clk);
      check("R3 err_ecc set", {31'b0, err_ecc}, 1);
      // R11: start-of-transmission recovers
      send_short(2'd0, 6'h21, 1'b1, 4'd11);

      // R11: abandon a pixel packet mid-payload
      send_hdr(2'd0, 6'h3E, 16'd6, 1'b0, 1'b0);
      put(8'h77, 1'b0);
      put(8'h88, 1'b0);
      send_short(2'd0, 6'h01, 1'b1, 4'd11);
      pay = '{8'h13, 8'h57, 8'h9B};
      send_long(2'd0, 6'h3E, 1'b0, 1'b0, 4'd11);
      repeat (3) @(negedge clk);
      check("R3 err_ecc sticky", {31'b0, err_ecc}, 1);
      check("R10 err_crc sticky", {31'b0, err_crc}, 1);

      repeat (10) @(negedge clk);
      check("R5 scoreboard drained", expq.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule